// File: doc/BRIEF.md
# Segment-Page Virtual Memory Translator

This block turns the processor's 32-bit virtual byte addresses into physical addresses. It walks two levels of tables. The current context and the segment field of the address pick an 8-bit segment entry. The low bits of that entry name a group of 32 page entries, and the page field of the address picks one entry in that group. The page entry supplies the physical frame, the target space and a valid bit. On a valid hit the block sets the entry's accessed bit. An invalid entry, or an address in the unused hole between the low and high halves of the space, produces a fault strobe instead of a bus transaction.

Every request carries an address-space identifier (ASI) of 8 bits:

- **Control space** (ASI 2) reads and writes the context register, the segment map and the page map. The top four address bits select which of these is reached.
- **Translated accesses** use ASIs 8 to 11 and walk the tables.
- **Boot fetches.** While the system is still in boot state, a supervisor program fetch (ASI 9 read) bypasses translation and goes to the boot ROM.
- **ROM window.** Space-1 reads inside a fixed physical window are also sent to the ROM.

Each request is accepted in a single cycle. Its results appear on registered outputs one cycle later. The block drives only the physical address, the write flag, the target space and the fault strobe. The memories, devices and caches behind it are outside the block.

Top module: `seg_xlat`

## Requirements
- R1: After reset the context register is 0, every segment and page entry is 0, and `ctl_rvalid`, `bus_valid` and `fault` are low.
- R2: A control write (ASI 2) with address bits [31:28]=3 loads the context register from data bits [24+CTX_BITS-1:24]. The write takes effect only when `req_be` is 4'b1000 or 4'b1100; any other byte-enable pattern is ignored. A read of the context register returns the value zero-extended to 8 bits:
  - in bits [23:16] when `req_be` is 4'b0100;
  - otherwise in bits [31:24], with all other bits zero.
- R3: A control access with bits [31:28]=5 reaches the 8-bit segment entry of the current context, indexed by address bits [18+SEG_BITS-1:18].
  - A write stores data bits [31:24], and only when `req_be` is 4'b1000 or 4'b1100; other patterns leave the entry unchanged.
  - Reads place the byte in the same lanes as R2.
- R4: A control access with bits [31:28]=4 reaches page entry {segment entry[PMEG_BITS-1:0], addr[17:13]}.
  - A write replaces each byte whose `req_be` bit is set (bit 3 is data bits [31:24]).
  - The written entry always has bits [23:19] forced to zero.
  - A read returns the whole 32-bit entry.
- R5: Control reads of any other region, including the region-map code 6, return 0. Control writes to those regions change no state.
- R6: For ASIs 8 to 11 (and not R10), an address with bits [31:30] equal to 00 or 11 selects its page entry as in R3 and R4. A page entry has valid bit 31 and type bits [27:26]. When the entry is valid, the physical address is {entry[18:0], addr[12:0]}.
  - Type 0 issues `bus_valid` with `bus_space`=0.
  - Type 1 issues `bus_valid` with `bus_space`=1 (unless R11).
  - `bus_write` equals `req_write`.
- R7: A translated access to a valid entry sets bit 25 of that stored entry.
- R8: A translated access to an entry with bit 31 clear pulses `fault` for one cycle, issues no bus transaction and leaves the entry unchanged.
- R9: A translated access whose address bits [31:30] are 01 or 10 pulses `fault` and issues no bus transaction.
- R10: While `run_mode` is 0, every ASI 9 read issues `bus_valid` with `bus_space`=2 (ROM) and `bus_paddr`={13'b0, addr[18:0]}. This happens whatever the tables hold and whatever the address. ASI 9 writes and other ASIs are still translated.
- R11: A translated read of a type-1 entry whose physical address lies in 0x0600_0000..0x06FF_FFFF goes to `bus_space`=2 with `bus_paddr`={13'b0, addr[18:0]}.
- R12: A valid entry of type 2 or 3 gives neither a bus transaction nor a fault, but still sets the accessed bit.
- R13: Every result appears in the cycle after the request is sampled, and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_mode | input | 1 | 0 while the system is in boot state |
| req_valid | input | 1 | Request present this cycle |
| req_asi | input | 8 | Address-space identifier |
| req_write | input | 1 | 1 for a write |
| req_addr | input | 32 | Virtual or control byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, bit 3 = bits [31:24] |
| ctl_rvalid | output | 1 | Control read data valid |
| ctl_rdata | output | 32 | Control read data |
| bus_valid | output | 1 | Physical access issued |
| bus_write | output | 1 | Physical access is a write |
| bus_space | output | 2 | 0 space 0, 1 space 1, 2 ROM |
| bus_paddr | output | 32 | Physical byte address |
| fault | output | 1 | Translation fault strobe |

## Verification
Every result of this block is one register stage behind its request:
- control read data;
- the physical access;
- the fault strobe.

The bench drives a request at the falling edge. It samples one nanosecond after the following rising edge, and it makes each comparison in that window before the next request is driven. Table updates (a map write or a set accessed bit) land on that same edge. A later control read therefore sees them, and its own data is again due one cycle after that read. One check drives an idle cycle after a request and confirms the outputs return to zero, which shows the one-cycle width.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int ASI_W        = 8;
    localparam int PAGE_SEL_W   = 5;
    localparam int PAGE_OFF_W   = 13;
    localparam int SEG_LSB      = PAGE_OFF_W + PAGE_SEL_W;
    localparam int ROM_ADDR_W   = 19;

    localparam logic [7:0] ASI_CTRL      = 8'd2;
    localparam logic [7:0] ASI_SUP_FETCH = 8'd9;

    localparam logic [3:0] RG_CONTEXT = 4'd3;
    localparam logic [3:0] RG_PAGE    = 4'd4;
    localparam logic [3:0] RG_SEGMENT = 4'd5;

    localparam int PTE_VALID_BIT = 31;
    localparam int PTE_REF_BIT   = 25;
    localparam logic [31:0] PTE_KEEP_MASK = 32'hFF07_FFFF;
    localparam logic [7:0]  ROM_WIN_HI    = 8'h06;

    typedef enum logic [1:0] {
        SP_TYPE0 = 2'd0,
        SP_TYPE1 = 2'd1,
        SP_ROM   = 2'd2
    } space_e;

    typedef struct packed {
        logic        ctl_rvalid;
        logic [31:0] ctl_rdata;
        logic        bus_valid;
        logic        bus_write;
        space_e      bus_space;
        logic [31:0] bus_paddr;
        logic        fault;
    } resp_t;
endpackage

// File: rtl/seg_store.sv
module seg_store #(
    parameter int CTX_BITS = 2,
    parameter int SEG_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CTX_BITS-1:0] ctx,
    input  logic [SEG_BITS-1:0] seg,
    input  logic                we,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata
);
    localparam int DEPTH = 1 << (CTX_BITS + SEG_BITS);

    logic [7:0] mem_q [DEPTH];
    logic [CTX_BITS+SEG_BITS-1:0] idx;

    assign idx   = {ctx, seg};
    assign rdata = mem_q[idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end
endmodule

// File: rtl/pte_store.sv
module pte_store #(
    parameter int IDX_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_BITS-1:0] idx,
    input  logic                we,
    input  logic [31:0]         wdata,
    input  logic                set_ref,
    output logic [31:0]         rdata
);
    import xlat_pkg::*;
    localparam int DEPTH = 1 << IDX_BITS;

    logic [31:0] mem_q [DEPTH];

    assign rdata = mem_q[idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[idx] <= wdata;
        end else if (set_ref) begin
            mem_q[idx][PTE_REF_BIT] <= 1'b1;
        end
    end

    // R7: the table reports the accessed bit set right after a marking update
    a_r7_ref_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ref && !we) |=> mem_q[$past(idx)][PTE_REF_BIT]);
endmodule

// File: rtl/seg_xlat.sv
module seg_xlat #(
    parameter int CTX_BITS  = 2,
    parameter int SEG_BITS  = 4,
    parameter int PMEG_BITS = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run_mode,
    input  logic        req_valid,
    input  logic [7:0]  req_asi,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic [3:0]  req_be,
    output logic        ctl_rvalid,
    output logic [31:0] ctl_rdata,
    output logic        bus_valid,
    output logic        bus_write,
    output logic [1:0]  bus_space,
    output logic [31:0] bus_paddr,
    output logic        fault
);
    import xlat_pkg::*;

    localparam int PTE_IDX_W = PMEG_BITS + PAGE_SEL_W;

    typedef struct packed {
        logic [CTX_BITS-1:0] ctx;
        resp_t               rsp;
    } state_t;

    state_t cur_q, nxt_d;

    logic [3:0]          region;
    logic [SEG_BITS-1:0] seg_sel;
    logic [7:0]          seg_ent;
    logic [PTE_IDX_W-1:0] pte_idx;
    logic [31:0]         pte_rd;
    logic [31:0]         pte_merged;
    logic [31:0]         phys;
    logic                seg_we, pte_we, pte_ref;
    logic                boot_hit, is_ctl, is_xl, hole;
    logic                top_lane_ok, lane1_only;
    logic [7:0]          rd_byte;
    logic [31:0]         rom_addr;

    assign region   = req_addr[31:28];
    assign seg_sel  = req_addr[SEG_LSB +: SEG_BITS];
    assign pte_idx  = {seg_ent[PMEG_BITS-1:0], req_addr[PAGE_OFF_W +: PAGE_SEL_W]};
    assign hole     = req_addr[31] ^ req_addr[30];
    assign phys     = {pte_rd[18:0], req_addr[PAGE_OFF_W-1:0]};
    assign rom_addr = {{(32-ROM_ADDR_W){1'b0}}, req_addr[ROM_ADDR_W-1:0]};

    assign boot_hit = req_valid && !req_write && !run_mode && (req_asi == ASI_SUP_FETCH);
    assign is_ctl   = req_valid && (req_asi == ASI_CTRL);
    assign is_xl    = req_valid && !boot_hit && (req_asi[7:2] == 6'b000010);

    assign top_lane_ok = (req_be == 4'b1000) || (req_be == 4'b1100);
    assign lane1_only  = (req_be == 4'b0100);

    logic unused_bits;
    assign unused_bits = ^{seg_ent, req_addr};

    seg_store #(.CTX_BITS(CTX_BITS), .SEG_BITS(SEG_BITS)) i_seg (
        .clk(clk), .rst_n(rst_n), .ctx(cur_q.ctx), .seg(seg_sel),
        .we(seg_we), .wdata(req_wdata[31:24]), .rdata(seg_ent)
    );

    pte_store #(.IDX_BITS(PTE_IDX_W)) i_pte (
        .clk(clk), .rst_n(rst_n), .idx(pte_idx), .we(pte_we),
        .wdata(pte_merged), .set_ref(pte_ref), .rdata(pte_rd)
    );

    always_comb begin
        for (int b = 0; b < 4; b++) begin
            pte_merged[b*8 +: 8] = req_be[b] ? req_wdata[b*8 +: 8] : pte_rd[b*8 +: 8];
        end
        pte_merged = pte_merged & PTE_KEEP_MASK;
    end

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.rsp = '0;
        seg_we    = 1'b0;
        pte_we    = 1'b0;
        pte_ref   = 1'b0;
        rd_byte   = '0;

        if (boot_hit) begin
            nxt_d.rsp.bus_valid = 1'b1;
            nxt_d.rsp.bus_space = SP_ROM;
            nxt_d.rsp.bus_paddr = rom_addr;
        end else if (is_ctl) begin
            nxt_d.rsp.ctl_rvalid = !req_write;
            case (region)
                RG_CONTEXT: begin
                    rd_byte = 8'(cur_q.ctx);
                    if (req_write && top_lane_ok) nxt_d.ctx = req_wdata[24 +: CTX_BITS];
                end
                RG_SEGMENT: begin
                    rd_byte = seg_ent;
                    seg_we  = req_write && top_lane_ok;
                end
                RG_PAGE: begin
                    pte_we = req_write;
                end
                default: ;
            endcase
            if (region == RG_PAGE)
                nxt_d.rsp.ctl_rdata = req_write ? '0 : pte_rd;
            else if (!req_write)
                nxt_d.rsp.ctl_rdata = lane1_only ? {8'h00, rd_byte, 16'h0000}
                                                 : {rd_byte, 24'h000000};
        end else if (is_xl) begin
            if (hole || !pte_rd[PTE_VALID_BIT]) begin
                nxt_d.rsp.fault = 1'b1;
            end else begin
                pte_ref = 1'b1;
                nxt_d.rsp.bus_write = req_write;
                case (pte_rd[27:26])
                    2'd0: begin
                        nxt_d.rsp.bus_valid = 1'b1;
                        nxt_d.rsp.bus_space = SP_TYPE0;
                        nxt_d.rsp.bus_paddr = phys;
                    end
                    2'd1: begin
                        nxt_d.rsp.bus_valid = 1'b1;
                        if (!req_write && phys[31:24] == ROM_WIN_HI) begin
                            nxt_d.rsp.bus_space = SP_ROM;
                            nxt_d.rsp.bus_paddr = rom_addr;
                        end else begin
                            nxt_d.rsp.bus_space = SP_TYPE1;
                            nxt_d.rsp.bus_paddr = phys;
                        end
                    end
                    default: nxt_d.rsp.bus_write = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign ctl_rvalid = cur_q.rsp.ctl_rvalid;
    assign ctl_rdata  = cur_q.rsp.ctl_rdata;
    assign bus_valid  = cur_q.rsp.bus_valid;
    assign bus_write  = cur_q.rsp.bus_write;
    assign bus_space  = cur_q.rsp.bus_space;
    assign bus_paddr  = cur_q.rsp.bus_paddr;
    assign fault      = cur_q.rsp.fault;

    // R8: a fault never comes with a physical access
    a_r8_fault_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !bus_valid);

    // R9: hole addresses fault on the next cycle
    a_r9_hole_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (is_xl && hole) |=> (fault && !bus_valid));

    // R10: boot-state supervisor fetches always reach the ROM
    a_r10_boot_rom: assert property (@(posedge clk) disable iff (!rst_n)
        boot_hit |=> (bus_valid && bus_space == 2'd2 && !fault));

    // R4: page entries never read back with the cleared field set
    a_r4_cleared_field: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctl && !req_write && region == RG_PAGE) |=> (ctl_rvalid && ctl_rdata[23:19] == 5'd0));

    // R5: other control regions read as zero
    a_r5_region_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctl && !req_write && region != RG_PAGE && region != RG_SEGMENT && region != RG_CONTEXT)
        |=> (ctl_rvalid && ctl_rdata == 32'd0));
endmodule

// File: tb/test_seg_xlat.sv
`timescale 1ns/1ps
module test_seg_xlat;
    localparam int CB = 2, SB = 4, PB = 3;

    logic clk = 1'b0, rst_n = 1'b0, run_mode = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_asi = '0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        ctl_rvalid, bus_valid, bus_write, fault;
    logic [31:0] ctl_rdata, bus_paddr;
    logic [1:0]  bus_space;

    int checks = 0, failures = 0;
    bit done = 0;

    logic [7:0]  seg_m [4][16];
    logic [31:0] pte_m [256];
    logic [1:0]  ctx_m = '0;

    always #2 clk = ~clk;

    seg_xlat #(.CTX_BITS(CB), .SEG_BITS(SB), .PMEG_BITS(PB)) i_seg_xlat (
        .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .req_valid(req_valid),
        .req_asi(req_asi), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .ctl_rvalid(ctl_rvalid),
        .ctl_rdata(ctl_rdata), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_space(bus_space), .bus_paddr(bus_paddr), .fault(fault)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic req(input logic [7:0] asi, input logic wr, input logic [31:0] a,
                       input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        req_valid = 1'b1; req_asi = asi; req_write = wr; req_addr = a;
        req_wdata = d; req_be = be;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk); @(posedge clk); #1;
    endtask

    function automatic logic [31:0] ctl_addr(input logic [3:0] rg, input logic [3:0] seg, input logic [4:0] pg);
        return {rg, 6'd0, seg, pg, 13'd0};
    endfunction

    function automatic logic [31:0] pte_val(input int idx);
        logic [18:0] pfn;
        logic v;
        v   = (idx % 7) != 3;
        pfn = 19'((idx * 713 + 4660) & 32'h7FFFF);
        if (idx % 8 == 5) pfn[18:11] = 8'h06;
        return {v, 3'b010, 2'(idx % 4), 1'b0, 1'b1, 5'h1F, pfn};
    endfunction

    task automatic set_ctx(input logic [1:0] c);
        req(8'd2, 1'b1, ctl_addr(4'd3, 4'd0, 5'd0), {6'd0, c, 24'h0}, 4'b1000);
        ctx_m = c;
    endtask

    task automatic write_seg(input logic [3:0] s, input logic [7:0] v, input logic [3:0] be);
        req(8'd2, 1'b1, ctl_addr(4'd5, s, 5'd0), {v, 24'h5A5A5A}, be);
        if (be == 4'b1000 || be == 4'b1100) seg_m[ctx_m][s] = v;
    endtask

    // expected translation, updates the model's accessed bits
    task automatic xl_check(input logic [7:0] asi, input logic wr, input logic [31:0] va, input string tag);
        logic eb, ef, ew; logic [1:0] es; logic [31:0] ep, p; int idx;
        eb = 0; ef = 0; ew = 0; es = 0; ep = 0;
        if (!run_mode && asi == 8'd9 && !wr) begin
            eb = 1; es = 2; ep = {13'd0, va[18:0]};
        end else if (va[31] != va[30]) begin
            ef = 1;
        end else begin
            idx = {seg_m[ctx_m][va[21:18]][2:0], va[17:13]};
            p = pte_m[idx];
            if (!p[31]) ef = 1;
            else begin
                pte_m[idx][25] = 1'b1;
                ep = {p[18:0], va[12:0]};
                if (p[27:26] == 2'd0) begin eb = 1; ew = wr; es = 0; end
                else if (p[27:26] == 2'd1) begin
                    eb = 1; ew = wr;
                    if (!wr && ep[31:24] == 8'h06) begin es = 2; ep = {13'd0, va[18:0]}; end
                    else es = 1;
                end else ep = 0;
            end
        end
        req(asi, wr, va, 32'h0, 4'hF);
        chk(bus_valid == eb && fault == ef && (!eb || (bus_space == es && bus_paddr == ep && bus_write == ew)),
            tag, {bus_valid, fault, bus_write, 27'd0, bus_space, bus_paddr},
            {eb, ef, ew, 27'd0, es, ep});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) for (int s = 0; s < 16; s++) seg_m[c][s] = '0;
        for (int i = 0; i < 256; i++) pte_m[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        chk(!ctl_rvalid && !bus_valid && !fault, "R1 outputs after reset",
            {ctl_rvalid, bus_valid, fault}, 0);
        rst_n = 1'b1;
        req(8'd2, 1'b0, ctl_addr(4'd3, 0, 0), 0, 4'hF);
        chk(ctl_rvalid && ctl_rdata == 0, "R1 context after reset", ctl_rdata, 0);
        req(8'd2, 1'b0, ctl_addr(4'd4, 4'd3, 5'd9), 0, 4'hF);
        chk(ctl_rdata == 0, "R1 page entry after reset", ctl_rdata, 0);

        // context register lanes and mask rules
        req(8'd2, 1'b1, ctl_addr(4'd3, 0, 0), 32'hA5FF_FFFF, 4'b1100);
        req(8'd2, 1'b0, ctl_addr(4'd3, 0, 0), 0, 4'hF);
        chk(ctl_rdata == 32'h0100_0000, "R2 context top lane", ctl_rdata, 32'h0100_0000);
        req(8'd2, 1'b0, ctl_addr(4'd3, 0, 0), 0, 4'b0100);
        chk(ctl_rdata == 32'h0001_0000, "R2 context lane1", ctl_rdata, 32'h0001_0000);
        req(8'd2, 1'b1, ctl_addr(4'd3, 0, 0), 32'h0200_0000, 4'b0010);
        req(8'd2, 1'b0, ctl_addr(4'd3, 0, 0), 0, 4'hF);
        chk(ctl_rdata == 32'h0100_0000, "R2 context odd mask ignored", ctl_rdata, 32'h0100_0000);
        set_ctx(2'd0);

        // fill all page groups through segment 0 of context 0
        for (int g = 0; g < 8; g++) begin
            write_seg(4'd0, 8'(g), 4'b1100);
            for (int p = 0; p < 32; p++) begin
                req(8'd2, 1'b1, ctl_addr(4'd4, 4'd0, 5'(p)), pte_val(g * 32 + p), 4'hF);
                pte_m[g * 32 + p] = pte_val(g * 32 + p) & 32'hFF07_FFFF;
            end
        end
        req(8'd2, 1'b0, ctl_addr(4'd4, 4'd0, 5'd4), 0, 4'hF);
        chk(ctl_rdata == pte_m[7 * 32 + 4], "R4 written entry has [23:19] cleared", ctl_rdata, pte_m[7 * 32 + 4]);
        req(8'd2, 1'b1, ctl_addr(4'd4, 4'd0, 5'd2), 32'h12FF_3456, 4'b0100);
        pte_m[7 * 32 + 2] = {pte_m[7 * 32 + 2][31:24], 8'hFF, pte_m[7 * 32 + 2][15:0]} & 32'hFF07_FFFF;
        req(8'd2, 1'b0, ctl_addr(4'd4, 4'd0, 5'd2), 0, 4'hF);
        chk(ctl_rdata == pte_m[7 * 32 + 2], "R4 byte-enable merge", ctl_rdata, pte_m[7 * 32 + 2]);

        // segment maps for every context
        for (int c = 0; c < 4; c++) begin
            set_ctx(2'(c));
            for (int s = 0; s < 16; s++)
                write_seg(4'(s), 8'(((c * 16 + s) * 37 + 11) & 255), (s % 2) ? 4'b1000 : 4'b1100);
        end
        write_seg(4'd6, 8'hEE, 4'b0010);
        write_seg(4'd6, 8'hEE, 4'b0100);
        req(8'd2, 1'b0, ctl_addr(4'd5, 4'd6, 0), 0, 4'hF);
        chk(ctl_rdata == {seg_m[3][6], 24'h0}, "R3 odd write masks ignored", ctl_rdata, {seg_m[3][6], 24'h0});
        req(8'd2, 1'b0, ctl_addr(4'd5, 4'd9, 0), 0, 4'b0100);
        chk(ctl_rdata == {8'h0, seg_m[3][9], 16'h0}, "R3 segment lane1 read", ctl_rdata, {8'h0, seg_m[3][9], 16'h0});
        set_ctx(2'd1);
        req(8'd2, 1'b0, ctl_addr(4'd5, 4'd9, 0), 0, 4'hF);
        chk(ctl_rdata == {seg_m[1][9], 24'h0}, "R3 segment per context", ctl_rdata, {seg_m[1][9], 24'h0});

        // other regions
        req(8'd2, 1'b1, ctl_addr(4'd6, 0, 0), 32'hFFFF_FFFF, 4'hF);
        req(8'd2, 1'b0, ctl_addr(4'd6, 0, 0), 0, 4'hF);
        chk(ctl_rvalid && ctl_rdata == 0, "R5 region map reads zero", ctl_rdata, 0);
        req(8'd2, 1'b0, ctl_addr(4'd7, 0, 0), 0, 4'hF);
        chk(ctl_rdata == 0, "R5 unused region reads zero", ctl_rdata, 0);
        req(8'd2, 1'b0, ctl_addr(4'd3, 0, 0), 0, 4'hF);
        chk(ctl_rdata == 32'h0100_0000, "R5 region write left context", ctl_rdata, 32'h0100_0000);

        // translation sweep: every context, segment, page
        for (int c = 0; c < 4; c++) begin
            set_ctx(2'(c));
            for (int s = 0; s < 16; s++)
                for (int p = 0; p < 32; p++)
                    xl_check(8'(8 + (s + p) % 4), ((s + p + c) % 3) == 0,
                             {(p % 2) ? 2'b11 : 2'b00, 8'(s * 13 + p), 4'(s), 5'(p), 13'(p * 331 + s * 17 + c)},
                             "R6 R8 R11 R12 translation sweep");
        end

        // accessed bits and unchanged invalid entries, read through the page map
        set_ctx(2'd0);
        for (int g = 0; g < 8; g++) begin
            write_seg(4'd0, 8'(g), 4'b1000);
            for (int p = 0; p < 32; p++) begin
                req(8'd2, 1'b0, ctl_addr(4'd4, 4'd0, 5'(p)), 0, 4'hF);
                chk(ctl_rdata == pte_m[g * 32 + p], "R7 R8 entry after sweep", ctl_rdata, pte_m[g * 32 + p]);
            end
        end

        // hole addresses
        xl_check(8'd8, 1'b0, 32'h4000_0000, "R9 hole 01");
        xl_check(8'd11, 1'b1, 32'hBFFF_FFFC, "R9 hole 10");
        idle();
        chk(!bus_valid && !fault && !ctl_rvalid, "R13 outputs last one cycle", {bus_valid, fault}, 0);

        // boot state
        run_mode = 1'b0;
        xl_check(8'd9, 1'b0, 32'h4ABC_DEF4, "R10 boot fetch hole address");
        xl_check(8'd9, 1'b0, 32'h0012_3458, "R10 boot fetch");
        xl_check(8'd9, 1'b0, 32'hFFF8_0000, "R10 boot fetch high");
        xl_check(8'd8, 1'b0, 32'h0000_8000, "R10 other ASI still translated");
        xl_check(8'd9, 1'b1, 32'h0004_2000, "R10 fetch-space write translated");
        run_mode = 1'b1;
        xl_check(8'd9, 1'b0, 32'h0004_A000, "R10 run mode translates ASI 9");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule